// File: doc/BRIEF.md
# Token-Ring Depth-Expandable FIFO

A FIFO slice built so that several copies, wired in a ring, act as one deeper FIFO. The write strobe, the read strobe and the write data go to every slice. Each slice has its own storage, write pointer, read pointer and occupancy counter. Two tokens move around the ring. The slice holding the write token is the only one that stores incoming words. The slice holding the read token is the only one that returns data.

A slice passes a token on when it accesses its own last physical location. It raises a one-cycle pulse on a dedicated line: one line for the write token and a separate line for the read token. The next slice samples that pulse at the same clock edge, takes the token, and starts its next access of that kind at location zero. The slice whose first-load input is low holds both tokens after reset.

Each slice reports active-low full and empty flags that only its token holder can assert. The top level chains a parameterised number of slices, three by default, and ANDs their flags together, so the composite flag is low when any slice drives it low. With a single slice, the top ties the slice into single-device mode: that slice keeps both tokens and wraps its pointers inside itself. Retransmit and half-full are not provided in this mode.

Top module: `fxp_chain`

## Requirements
- R1: After reset, `empty_n` is 0, `full_n` is 1 and `dout_vld` is 0. Slice 0 (first-load low) holds both tokens and the other slices hold none.
- R2: Words are returned in the order they were accepted, including across the boundaries between slices and around the ring.
- R3: Exactly one slice holds the write token and exactly one holds the read token at any time. Writing a slice's last location raises its write handoff pulse and moves the write token to the next slice in the same cycle. Reading a slice's last location does the same for the read token.
- R4: `full_n` goes to 0 exactly when N_SLICE*DEPTH words (24 by default) are stored. A write while `full_n` is 0 is ignored and no stored word changes.
- R5: `empty_n` goes to 0 exactly when no word is stored. A read while `empty_n` is 0 is ignored and `dout_vld` stays 0 in the next cycle.
- R6: An accepted read returns its word on `dout` with `dout_vld`=1 in the cycle after the read strobe. When no read is accepted, `dout_vld` is 0 and `dout` is all zeros.
- R7: A read and a write in the same cycle on a FIFO that is neither empty nor full are both accepted. The occupancy does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe, shared by all slices |
| din | input | DW | Write data, shared by all slices |
| rd_en | input | 1 | Read strobe, shared by all slices |
| dout | output | DW | Read data, OR of the slices' gated outputs |
| dout_vld | output | 1 | High in the cycle that `dout` holds a read word |
| full_n | output | 1 | Composite full flag, active low |
| empty_n | output | 1 | Composite empty flag, active low |

## Verification
A read strobe sampled at edge k gives `dout`/`dout_vld` right after edge k. The flags reflect the occupancy after that same edge, because they are decoded combinationally from registered counts. The bench drives the strobes between edges and samples one time unit after the following edge. There it compares against a queue model that pops a word before it pushes one and decides full and empty from the occupancy before the edge. The write handoff is combinational, so a write in the cycle right after a boundary crossing must land in the next slice. The back-to-back write sweeps check this.

// File: rtl/fxp_pkg.sv
package fxp_pkg;
  // true when pointer p addresses the last physical word of a depth-d slice
  function automatic logic ptr_at_last(input int unsigned p, input int unsigned d);
    return p == d - 1;
  endfunction

  // pointer advance with wrap to location zero
  function automatic int unsigned ptr_next(input int unsigned p, input int unsigned d);
    return (p == d - 1) ? 0 : p + 1;
  endfunction
endpackage

// File: rtl/fxp_slice.sv
module fxp_slice
  import fxp_pkg::*;
#(
  parameter int DW    = 9,
  parameter int DEPTH = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          first_ld_n,
  input  logic          solo,
  input  logic          wr_en,
  input  logic [DW-1:0] din,
  input  logic          rd_en,
  input  logic          xin_wr,
  input  logic          xin_rd,
  output logic          xout_wr,
  output logic          xout_rd,
  output logic [DW-1:0] dout,
  output logic          dout_vld,
  output logic          full_n,
  output logic          empty_n,
  output logic          has_wr,
  output logic          has_rd
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic [CW-1:0] cnt;
  logic          wr_tok, rd_tok;

  // named internal events
  logic wr_fire, rd_fire, wr_last, rd_last, slice_full, slice_empty;

  assign slice_full  = (cnt == CW'(DEPTH));
  assign slice_empty = (cnt == '0);
  assign wr_fire     = wr_en & wr_tok & ~slice_full;
  assign rd_fire     = rd_en & rd_tok & ~slice_empty;
  assign wr_last     = wr_fire & ptr_at_last(int'(wptr), DEPTH);
  assign rd_last     = rd_fire & ptr_at_last(int'(rptr), DEPTH);
  assign xout_wr     = wr_last & ~solo;
  assign xout_rd     = rd_last & ~solo;
  assign full_n      = ~(wr_tok & slice_full);
  assign empty_n     = ~(rd_tok & slice_empty);
  assign has_wr      = wr_tok;
  assign has_rd      = rd_tok;

  always_ff @(posedge clk) begin
    if (wr_fire) mem[wptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wptr     <= '0;
      rptr     <= '0;
      cnt      <= '0;
      wr_tok   <= ~first_ld_n | solo;
      rd_tok   <= ~first_ld_n | solo;
      dout     <= '0;
      dout_vld <= 1'b0;
    end else begin
      if (wr_fire) wptr <= AW'(ptr_next(int'(wptr), DEPTH));
      if (rd_fire) rptr <= AW'(ptr_next(int'(rptr), DEPTH));
      cnt <= cnt + CW'(wr_fire) - CW'(rd_fire);
      if (xout_wr)               wr_tok <= 1'b0;
      else if (xin_wr && !solo)  wr_tok <= 1'b1;
      if (xout_rd)               rd_tok <= 1'b0;
      else if (xin_rd && !solo)  rd_tok <= 1'b1;
      dout     <= rd_fire ? mem[rptr] : '0;
      dout_vld <= rd_fire;
    end
  end

  // R3: a write handoff leaves this slice without the write token
  p_wr_handoff_r3: assert property (@(posedge clk) disable iff (!rst_n)
    xout_wr |=> !has_wr);
  // R3: a read handoff leaves this slice without the read token
  p_rd_handoff_r3: assert property (@(posedge clk) disable iff (!rst_n)
    xout_rd |=> !has_rd);
  // R4: a write refused on full leaves the write pointer where it was
  p_full_blocks_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!full_n && wr_en) |=> $stable(wptr));
  // R5: no data is returned after a strobe seen while empty
  p_empty_no_data_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!empty_n && !xin_rd) |=> !dout_vld);
  // R6: output is all zeros whenever it is not valid
  p_zero_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !dout_vld |-> (dout == '0));
endmodule

// File: rtl/fxp_chain.sv
module fxp_chain #(
  parameter int DW      = 9,
  parameter int DEPTH   = 8,
  parameter int N_SLICE = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [DW-1:0] din,
  input  logic          rd_en,
  output logic [DW-1:0] dout,
  output logic          dout_vld,
  output logic          full_n,
  output logic          empty_n
);
  localparam logic SOLO = (N_SLICE == 1);

  logic [N_SLICE-1:0] xo_wr, xo_rd, xi_wr, xi_rd;
  logic [N_SLICE-1:0] vld_s, full_s, empty_s, tok_wr, tok_rd;
  logic [DW-1:0]      dout_s [N_SLICE];

  for (genvar i = 0; i < N_SLICE; i++) begin : g_slice
    // ring: each slice hears the previous one, slice 0 hears the last
    assign xi_wr[i] = xo_wr[(i + N_SLICE - 1) % N_SLICE];
    assign xi_rd[i] = xo_rd[(i + N_SLICE - 1) % N_SLICE];

    fxp_slice #(.DW(DW), .DEPTH(DEPTH)) u_slice (
      .clk       (clk),
      .rst_n     (rst_n),
      .first_ld_n(i != 0),
      .solo      (SOLO),
      .wr_en     (wr_en),
      .din       (din),
      .rd_en     (rd_en),
      .xin_wr    (xi_wr[i]),
      .xin_rd    (xi_rd[i]),
      .xout_wr   (xo_wr[i]),
      .xout_rd   (xo_rd[i]),
      .dout      (dout_s[i]),
      .dout_vld  (vld_s[i]),
      .full_n    (full_s[i]),
      .empty_n   (empty_s[i]),
      .has_wr    (tok_wr[i]),
      .has_rd    (tok_rd[i])
    );
  end

  always_comb begin
    dout = '0;
    for (int i = 0; i < N_SLICE; i++) dout |= dout_s[i];
  end

  assign dout_vld = |vld_s;
  assign full_n   = &full_s;
  assign empty_n  = &empty_s;

  // R3: one write-token holder and one read-token holder at all times
  p_one_wr_tok_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot(tok_wr));
  p_one_rd_tok_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot(tok_rd));
  // R6: at most one slice returns data in a cycle
  p_one_driver_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(vld_s));
  // R1: the first-load slice starts with both tokens
  p_first_tok_r1: assert property (@(posedge clk)
    $fell(rst_n) |=> (tok_wr[0] && tok_rd[0]));
endmodule

// File: tb/tb_fxp_chain.sv
module tb_fxp_chain;
  localparam int DW = 9, DEPTH = 8, NS = 3, CAP = DEPTH * NS;

  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
  logic [DW-1:0] din = '0, dout;
  logic dout_vld, full_n, empty_n;
  int checks = 0, errors = 0;
  logic [DW-1:0] model[$];

  always #2.5 clk = ~clk;

  fxp_chain #(.DW(DW), .DEPTH(DEPTH), .N_SLICE(NS)) dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .din(din), .rd_en(rd_en),
    .dout(dout), .dout_vld(dout_vld), .full_n(full_n), .empty_n(empty_n));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // one clock: strobes applied before the edge, results sampled 1 unit after
  task automatic cyc(input bit w, input logic [DW-1:0] d, input bit r, input string tag);
    bit exp_v = 1'b0;
    logic [DW-1:0] exp_d = '0;
    wr_en = w; din = d; rd_en = r;
    if (r && model.size() != 0) begin exp_v = 1'b1; exp_d = model.pop_front(); end
    if (w && (model.size() + (exp_v ? 1 : 0)) != CAP) model.push_back(d);
    @(posedge clk); #1;
    wr_en = 1'b0; rd_en = 1'b0;
    check(dout_vld == exp_v, {tag, " R6 valid"}, int'(dout_vld), int'(exp_v));
    check(dout == exp_d, {tag, " R2 data order"}, int'(dout), int'(exp_d));
    check(full_n == (model.size() != CAP), {tag, " R4 full_n"}, int'(full_n), int'(model.size() != CAP));
    check(empty_n == (model.size() != 0), {tag, " R5 empty_n"}, int'(empty_n), int'(model.size() != 0));
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    #1;
    // R1 reset state
    check(empty_n == 1'b0, "R1 empty_n after reset", int'(empty_n), 0);
    check(full_n == 1'b1, "R1 full_n after reset", int'(full_n), 1);
    check(dout_vld == 1'b0, "R1 dout_vld after reset", int'(dout_vld), 0);
    @(negedge clk);
    // R5 read while empty is ignored
    cyc(1'b0, '0, 1'b1, "R5 empty read");
    // fill all 24 words back to back; R3 handoff at each slice boundary
    for (int i = 0; i < CAP; i++) cyc(1'b1, DW'(i * 7 + 3), 1'b0, "R3 R4 fill");
    // R4 write while full is ignored
    cyc(1'b1, 9'h1AA, 1'b0, "R4 write on full");
    // drain all, order across boundaries (R2, R3), then empty (R5)
    for (int i = 0; i < CAP; i++) cyc(1'b0, '0, 1'b1, "R2 R3 drain");
    cyc(1'b0, '0, 1'b1, "R5 read after drain");
    // R7 simultaneous read/write sweep with wrap around the ring
    for (int i = 0; i < 5; i++) cyc(1'b1, DW'(100 + i), 1'b0, "R7 prefill");
    for (int i = 0; i < 60; i++) cyc(1'b1, DW'(200 + i * 3), 1'b1, "R7 same cycle");
    // partial fill to full from a rotated token position
    while (model.size() != CAP) cyc(1'b1, DW'(model.size() * 5 + 1), 1'b0, "R4 refill");
    cyc(1'b1, 9'h055, 1'b1, "R4 R7 rw on full");
    cyc(1'b1, 9'h0F0, 1'b0, "R4 write on full again");
    // mixed pattern drain
    for (int i = 0; i < 80; i++) cyc(i % 3 == 0, DW'(i + 300), i % 3 != 0, "R2 mixed");
    while (model.size() != 0) cyc(1'b0, '0, 1'b1, "R5 final drain");
    cyc(1'b1, 9'h011, 1'b1, "R5 write+read on empty");
    cyc(1'b0, '0, 1'b1, "R6 single word return");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule